// File: doc/BRIEF.md
# Incremental ROM Checksum Verifier

This block confirms that program memory has not been corrupted. It reads the ROM one word at a time and runs the words through a CRC-16 (polynomial 0x1021, seed 0xFFFF). It then compares the result with the reference value held in the highest ROM address. The CRC never includes that highest word.

The scan is meant to run only when the memory port would otherwise sit unused. The block raises a request, and it advances one word in each cycle in which the grant input is high. When the grant drops, the block pauses after the current word. The running CRC and the next address stay in registers while it waits.

The image is split into blocks of a parameterized number of words. After each complete block the block releases the port for one cycle. When a pass ends it produces a one-cycle done pulse, a pass level and a sticky fail flag. It then either sits idle or, when periodic mode is enabled, starts the next pass on its own.

Top module: `rom_crc_scanner`

## Requirements
- R1: Reset state. After reset req_o, done_o, pass_o and fail_o are 0, rom_addr_o and progress_o are 0, and no scan begins until restart_i is seen.
- R2: Word order. Words are fetched in ascending address order starting at 0. One word is consumed in each cycle in which req_o and grant_i are both high, and rom_addr_o then moves to the next address.
- R3: Pausing. In a cycle with req_o high and grant_i low, rom_addr_o, progress_o and the running CRC keep their values, and req_o stays high.
- R4: Block boundary. After every BLOCK_WORDS consumed words that do not end the pass, req_o goes low for exactly one cycle and progress_o increases by one. A full pass of the default 64-word ROM in 8-word blocks therefore has 7 such gaps and ends with progress_o = 8.
- R5: Checksum. Words 0 to DEPTH-2 are fed into the CRC most significant bit first. The word at DEPTH-1 is read as the last granted access of a pass and compared with the CRC. done_o is high for one cycle, in the cycle after that access, and from then on req_o stays low.
- R6: Pass level. pass_o becomes 1 when the compared values are equal and 0 when they differ. It keeps that value through later passes until the next comparison or a restart_i, which clears it.
- R7: Sticky fail. fail_o is set by a mismatch and cleared only by fail_clr_i. When a mismatch and fail_clr_i fall in the same cycle, fail_o stays set.
- R8: Restart. restart_i from any state clears the address, the progress count, the CRC and pass_o, and starts a pass. In the next cycle req_o is high and rom_addr_o is 0. A grant in the same cycle as restart_i consumes nothing.
- R9: Periodic mode. In the finished state, periodic_en_i high starts a new pass in the next cycle with the address and progress reset to 0. While periodic_en_i is low the block stays idle with req_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Begin a fresh pass |
| periodic_en_i | input | 1 | Start the next pass automatically after one finishes |
| grant_i | input | 1 | The memory port is free in this cycle |
| fail_clr_i | input | 1 | Clear the sticky fail flag |
| rom_data_i | input | DATA_W | ROM word at rom_addr_o, valid in the same cycle |
| req_o | output | 1 | Requests the memory port |
| rom_addr_o | output | ADDR_W | Address of the next word to read |
| progress_o | output | PROG_W | Number of blocks completed in the current pass |
| done_o | output | 1 | One-cycle pulse when a pass finishes |
| pass_o | output | 1 | Result of the last comparison was a match |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
The final comparison and the clearing of the fail flag can land in the same clock edge. The bench provokes this by watching for the cycle in which rom_addr_o points at the reference word with the grant high, and raising fail_clr_i in exactly that cycle. With a corrupted image, fail_o must still read 1 in the done cycle. A second collision is a restart arriving together with a grant in the middle of a block: nothing may be consumed, and the next pass must start again from address 0 and reach a correct verdict.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } scan_state_e;
endpackage

// File: rtl/rcs_crc_step.sv
module rcs_crc_step #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = crc_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][CRC_W-1] ^ data_i[DATA_W-1-g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/rcs_crc_acc.sv
module rcs_crc_acc #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      step_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [rcs_pkg::CRC_W-1:0] crc_o
);
  import rcs_pkg::*;

  logic [CRC_W-1:0] crc_q, crc_nxt;

  rcs_crc_step #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC_POLY)
  ) u_step (
    .crc_i  (crc_q),
    .data_i (data_i),
    .crc_o  (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_SEED;
    else if (clear_i) crc_q <= CRC_SEED;
    else if (step_i)  crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rcs_scan_ctrl.sv
module rcs_scan_ctrl #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned PROG_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              periodic_en_i,
  input  logic              grant_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PROG_W-1:0] progress_o,
  output logic              start_o,
  output logic              step_o,
  output logic              cmp_o
);
  import rcs_pkg::*;

  localparam int unsigned BLK_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [BLK_W-1:0]  BLK_END   = BLK_W'(BLOCK_WORDS - 1);

  scan_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [PROG_W-1:0] prog_q, prog_d;
  logic consume, is_last, start;

  assign req_o   = (state_q == ST_SCAN);
  assign consume = req_o && grant_i && !restart_i;
  assign is_last = (addr_q == LAST_ADDR);
  assign start   = restart_i || ((state_q == ST_DONE) && periodic_en_i);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    blk_d   = blk_q;
    prog_d  = prog_q;
    if (start) begin
      state_d = ST_SCAN;
      addr_d  = '0;
      blk_d   = '0;
      prog_d  = '0;
    end else begin
      unique case (state_q)
        ST_SCAN: if (consume) begin
          if (is_last) begin
            state_d = ST_DONE;
            prog_d  = prog_q + 1'b1;
          end else begin
            addr_d = addr_q + 1'b1;
            if (blk_q == BLK_END) begin
              state_d = ST_GAP;
              blk_d   = '0;
              prog_d  = prog_q + 1'b1;
            end else begin
              blk_d = blk_q + 1'b1;
            end
          end
        end
        ST_GAP:  state_d = ST_SCAN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      blk_q   <= '0;
      prog_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      blk_q   <= blk_d;
      prog_q  <= prog_d;
    end
  end

  assign addr_o     = addr_q;
  assign progress_o = prog_q;
  assign start_o    = start;
  assign step_o     = consume && !is_last;
  assign cmp_o      = consume && is_last;
endmodule

// File: rtl/rcs_verdict.sv
module rcs_verdict #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      restart_i,
  input  logic                      fail_clr_i,
  input  logic                      cmp_i,
  input  logic [rcs_pkg::CRC_W-1:0] crc_i,
  input  logic [DATA_W-1:0]         ref_i,
  output logic                      done_o,
  output logic                      pass_o,
  output logic                      fail_o
);
  import rcs_pkg::*;

  logic done_q, pass_q, fail_q, match;

  assign match = (ref_i[CRC_W-1:0] == crc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= cmp_i;
      if (restart_i)  pass_q <= 1'b0;
      else if (cmp_i) pass_q <= match;
      // a new mismatch outranks a clear in the same cycle
      fail_q <= (fail_q && !fail_clr_i) || (cmp_i && !match);
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/rom_crc_scanner.sv
module rom_crc_scanner #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned PROG_W      = $clog2(((1 << ADDR_W) + BLOCK_WORDS - 1) / BLOCK_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              periodic_en_i,
  input  logic              grant_i,
  input  logic              fail_clr_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic [PROG_W-1:0] progress_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  import rcs_pkg::*;

  logic start, step, cmp;
  logic [CRC_W-1:0] crc;

  rcs_scan_ctrl #(
    .ADDR_W      (ADDR_W),
    .BLOCK_WORDS (BLOCK_WORDS),
    .PROG_W      (PROG_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (restart_i),
    .periodic_en_i (periodic_en_i),
    .grant_i       (grant_i),
    .req_o         (req_o),
    .addr_o        (rom_addr_o),
    .progress_o    (progress_o),
    .start_o       (start),
    .step_o        (step),
    .cmp_o         (cmp)
  );

  rcs_crc_acc #(.DATA_W(DATA_W)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .step_i  (step),
    .data_i  (rom_data_i),
    .crc_o   (crc)
  );

  rcs_verdict #(.DATA_W(DATA_W)) u_verdict (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .fail_clr_i (fail_clr_i),
    .cmp_i      (cmp),
    .crc_i      (crc),
    .ref_i      (rom_data_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restart_i,
  input logic              grant_i,
  input logic              fail_clr_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && grant_i && !restart_i && rom_addr_o != LAST_ADDR)
      |=> rom_addr_o == ADDR_W'($past(rom_addr_o) + 1'b1));

  p_pause_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i && !restart_i) |=> ($stable(rom_addr_o) && req_o));

  p_done_drops_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);

  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !fail_clr_i) |=> fail_o);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (req_o && rom_addr_o == '0 && !pass_o && !done_o));
endmodule

bind rom_crc_scanner rcs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .restart_i  (restart_i),
  .grant_i    (grant_i),
  .fail_clr_i (fail_clr_i),
  .req_o      (req_o),
  .rom_addr_o (rom_addr_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/rom_crc_scanner_tb.sv
module rom_crc_scanner_tb;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BLK    = 8;
  localparam int PW     = 4;
  localparam int NVEC   = 4;
  // vector table: grant pattern (cycled), corrupted word (-1 none), expected pass
  localparam logic [3:0] V_PAT  [NVEC] = '{4'b1111, 4'b0101, 4'b0110, 4'b0001};
  localparam int         V_BAD  [NVEC] = '{-1, 5, DEPTH-2, DEPTH-1};
  localparam logic       V_PASS [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 0, rst_n = 0;
  logic restart = 0, periodic = 0, grant = 0, fail_clr = 0;
  logic [15:0] rom [DEPTH];
  logic [15:0] rom_data;
  logic req, done, pass, fail;
  logic [ADDR_W-1:0] addr;
  logic [PW-1:0] prog;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  assign rom_data = rom[addr];

  rom_crc_scanner #(.ADDR_W(ADDR_W), .DATA_W(16), .BLOCK_WORDS(BLK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .periodic_en_i(periodic),
    .grant_i(grant), .fail_clr_i(fail_clr), .rom_data_i(rom_data),
    .req_o(req), .rom_addr_o(addr), .progress_o(prog),
    .done_o(done), .pass_o(pass), .fail_o(fail));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < DEPTH - 1; i++)
      for (int b = 15; b >= 0; b--) begin
        logic fb = c[15] ^ rom[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic fill_rom();
    for (int i = 0; i < DEPTH - 1; i++) rom[i] = 16'(i * 40503 + 7) ^ 16'hA5C3;
    rom[DEPTH-1] = crc_ref();
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1; grant = 1;
    @(negedge clk); restart = 0; grant = 0;
  endtask

  // drive grant from a pattern until done_o; count words, gaps, pause violations
  task automatic run_pass(input logic [3:0] pat, output int words, output int gaps,
                          output int hold_err, output int gap_err);
    logic pg = 0, pr = 1;
    logic [ADDR_W-1:0] pa = addr;
    int k = 0;
    words = 0; gaps = 0; hold_err = 0; gap_err = 0;
    while (1) begin
      if (pr && pg) words++;
      if (pr && !pg && addr != pa) hold_err++;
      if (done) break;
      if (!req) begin
        gaps++;
        if (words % BLK != 0) gap_err++;
      end
      if (k > 2000) break;
      pg = pat[k % 4]; grant = pg;
      pr = req; pa = addr; k++;
      @(negedge clk);
    end
    grant = 0;
  endtask

  int w, g, h, ge;
  logic exp_pass;

  initial begin
    fill_rom();
    #1;
    chk(req == 0 && done == 0 && pass == 0 && fail == 0, "R1 outputs after reset", {req, done, pass, fail}, 0);
    chk(addr == 0 && prog == 0, "R1 address/progress after reset", addr, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    grant = 1;
    @(negedge clk);
    chk(req == 0 && addr == 0, "R1 idle without restart", req, 0);
    grant = 0;

    for (int v = 0; v < NVEC; v++) begin
      fill_rom();
      if (V_BAD[v] >= 0) rom[V_BAD[v]] = rom[V_BAD[v]] ^ 16'h0040;
      exp_pass = (crc_ref() == rom[DEPTH-1]);
      chk(exp_pass == V_PASS[v], "R5 table expectation", exp_pass, V_PASS[v]);
      do_restart();
      chk(req && addr == 0 && prog == 0, "R8 restart starts pass", addr, 0);
      run_pass(V_PAT[v], w, g, h, ge);
      chk(done == 1, "R5 done pulse", done, 1);
      chk(w == DEPTH, "R2 granted words per pass", w, DEPTH);
      chk(g == 7 && ge == 0, "R4 block gaps", g, 7);
      chk(prog == 8, "R4 progress at end", prog, 8);
      chk(h == 0, "R3 address held while not granted", h, 0);
      chk(pass == V_PASS[v], "R6 pass level", pass, V_PASS[v]);
      chk(fail == !V_PASS[v], "R7 fail flag", fail, !V_PASS[v]);
      @(negedge clk);
      chk(done == 0 && req == 0, "R5 done one cycle, no request", {done, req}, 0);
      fail_clr = 1; @(negedge clk); fail_clr = 0;
      chk(fail == 0, "R7 fail cleared", fail, 0);
    end

    // R7 sticky across a later good pass
    fill_rom(); rom[9] = ~rom[9];
    do_restart(); run_pass(4'b1111, w, g, h, ge);
    chk(fail == 1, "R7 mismatch sets fail", fail, 1);
    fill_rom();
    do_restart(); run_pass(4'b1111, w, g, h, ge);
    chk(pass == 1 && fail == 1, "R7 fail sticky across good pass", {pass, fail}, 3);
    fail_clr = 1; @(negedge clk); fail_clr = 0;

    // R7 collision: clear in the same cycle as a failing compare
    rom[20] = ~rom[20];
    do_restart();
    grant = 1;
    while (!(req && addr == DEPTH - 1) && cyc < 100000) @(negedge clk);
    fail_clr = 1;
    @(negedge clk); fail_clr = 0; grant = 0;
    chk(done == 1 && fail == 1, "R7 set wins over clear", {done, fail}, 3);
    fail_clr = 1; @(negedge clk); fail_clr = 0;

    // R8 restart mid-block with grant, then a clean pass
    fill_rom();
    do_restart();
    grant = 1; repeat (13) @(negedge clk);
    restart = 1; @(negedge clk); restart = 0; grant = 0;
    chk(req && addr == 0 && prog == 0, "R8 restart mid-pass clears", addr, 0);
    chk(pass == 0, "R8 restart clears pass", pass, 0);
    run_pass(4'b1011, w, g, h, ge);
    chk(pass == 1 && fail == 0 && w == DEPTH, "R8 pass after restart", w, DEPTH);

    // R9 periodic
    repeat (5) @(negedge clk);
    chk(req == 0 && done == 0, "R9 idle with periodic low", req, 0);
    periodic = 1; @(negedge clk); periodic = 0;
    chk(req && addr == 0 && prog == 0, "R9 periodic starts pass", {req, addr}, 64);
    chk(pass == 1, "R6 pass held into new pass", pass, 1);
    run_pass(4'b1111, w, g, h, ge);
    chk(done && pass && w == DEPTH, "R9 periodic pass completes", w, DEPTH);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule